// File: doc/BRIEF.md
# Rectangular DMA Address Generator

This block produces one source address and one destination address for every transfer of a DMA channel. A one-cycle `start` pulse loads a run configuration: the two base addresses, a transfer unit size, an increment code for each side, the number of transfers per line minus one, a rectangular-copy enable, the number of lines minus one, and a stride for each side. The generator then presents address pairs on an output stream until the run is finished. Data movement, the bus and the channel arbiter sit outside the block. The engine that performs the bus accesses consumes the stream.

With rectangular copy off, the run is a single line of transfers. With it on, the run is a block of lines. After the last transfer of a line, each side restarts at the start address of that line plus its own stride, and the per-line transfer counter is reloaded. The final transfer of every line is flagged, and the final transfer of the last line is flagged separately.

The output is a valid/ready stream. The block raises `out_valid` one cycle after an accepted `start`. A transfer is consumed on any rising clock edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, every output holds its value. `out_ready` has no effect while `out_valid` is low.

Top module: `rdag_top`

## Requirements
- R1: After reset, `out_valid` is low, and it stays low until a `start` is accepted.
- R2: A `start` pulse received while `out_valid` is low loads the configuration. `out_valid` is high from the next cycle on, and the first pair equals the two base addresses.
- R3: Within a line, each side advances by its own increment code after every consumed transfer: code 0 adds 1, code 1 adds 2, code 2 adds 4 and code 3 adds 0 (the address stays fixed).
- R4: `size_code` equals the 2-bit `cfg_size` value captured at `start` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), and it is held for the whole run.
- R5: A line has `cfg_count_m1` + 1 transfers, up to 1024 with the 10-bit default. `line_last` is high exactly on the last transfer of each line.
- R6: When `cfg_rect_en` = 1, the run has `cfg_lines_m1` + 1 lines. Each new line starts, per side, at the previous line's start address plus that side's stride. When `cfg_rect_en` = 0, the run is one line and `cfg_lines_m1` is ignored.
- R7: `block_last` is high only on the final transfer of the final line, and only together with `line_last`. After that transfer is consumed, `out_valid` falls and stays low until the next accepted `start`.
- R8: While `out_valid` is high and `out_ready` is low, the addresses, `size_code`, `line_last` and `block_last` hold their values.
- R9: A `start` pulse received while `out_valid` is high is ignored. Changes to the configuration inputs during a run do not alter the address sequence of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the present configuration |
| cfg_src_base | input | ADDR_W | Source start address |
| cfg_dst_base | input | ADDR_W | Destination start address |
| cfg_size | input | 2 | Transfer unit size code |
| cfg_src_inc | input | 2 | Source increment code |
| cfg_dst_inc | input | 2 | Destination increment code |
| cfg_count_m1 | input | CNT_W | Transfers per line minus one |
| cfg_rect_en | input | 1 | Enable rectangular (multi-line) copy |
| cfg_lines_m1 | input | LINE_W | Lines per block minus one |
| cfg_src_stride | input | STRIDE_W | Source distance between line starts |
| cfg_dst_stride | input | STRIDE_W | Destination distance between line starts |
| out_valid | output | 1 | An address pair is presented |
| out_ready | input | 1 | Consumer accepts the presented pair |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| size_code | output | 2 | Captured transfer size code |
| line_last | output | 1 | Last transfer of the current line |
| block_last | output | 1 | Last transfer of the whole run |

## Verification
The bench tries all sixteen pairs of source and destination increment codes against several line and block shapes. The shapes are a single transfer, a short line, a line with rectangular copy off but a nonzero line count, and multi-line blocks. Running different codes on the two sides shows that each side follows its own code. The multi-line blocks separate a restart at the stride from a simple continuation of the increment, and they show whether the line count is honoured or ignored. Runs alternate between a ready that is always high and a stuttering ready, so a stall that moves an address can be told apart from a correct hold. Some runs also pulse `start` and change the configuration mid-run. A further run at the full 1024-transfer line checks the counter at its boundary.

// File: rtl/rdag_pkg.sv
package rdag_pkg;

  typedef enum logic [1:0] {
    INC_BYTE = 2'd0,
    INC_HALF = 2'd1,
    INC_WORD = 2'd2,
    INC_HOLD = 2'd3
  } inc_code_e;

  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_SRC  = 0;
  localparam int unsigned SIDE_DST  = 1;

  function automatic logic [2:0] inc_bytes(inc_code_e code);
    case (code)
      INC_BYTE: inc_bytes = 3'd1;
      INC_HALF: inc_bytes = 3'd2;
      INC_WORD: inc_bytes = 3'd4;
      default:  inc_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rdag_side.sv
module rdag_side
  import rdag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   base,
  input  logic [1:0]          inc_code,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                step,
  input  logic                next_line,
  output logic [ADDR_W-1:0]   addr
);

  localparam int unsigned PAD_INC = ADDR_W - 3;
  localparam int unsigned PAD_STR = ADDR_W - STRIDE_W;

  logic [ADDR_W-1:0]   cur_q;
  logic [ADDR_W-1:0]   line_start_q;
  inc_code_e           inc_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [ADDR_W-1:0]   inc_ext;
  logic [ADDR_W-1:0]   stride_ext;
  logic [ADDR_W-1:0]   next_start;

  assign inc_ext    = {{PAD_INC{1'b0}}, inc_bytes(inc_q)};
  assign stride_ext = {{PAD_STR{1'b0}}, stride_q};
  assign next_start = line_start_q + stride_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q        <= '0;
      line_start_q <= '0;
      inc_q        <= INC_BYTE;
      stride_q     <= '0;
    end else if (load) begin
      cur_q        <= base;
      line_start_q <= base;
      inc_q        <= inc_code_e'(inc_code);
      stride_q     <= stride;
    end else if (next_line) begin
      cur_q        <= next_start;
      line_start_q <= next_start;
    end else if (step) begin
      cur_q        <= cur_q + inc_ext;
    end
  end

  assign addr = cur_q;

endmodule

// File: rtl/rdag_counter.sv
module rdag_counter #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  count_m1,
  input  logic              rect_en,
  input  logic [LINE_W-1:0] lines_m1,
  input  logic              fire,
  output logic              line_end,
  output logic              block_end,
  output logic              step,
  output logic              next_line
);

  logic [CNT_W-1:0]  xfer_left_q;
  logic [CNT_W-1:0]  reload_q;
  logic [LINE_W-1:0] lines_left_q;

  assign line_end  = (xfer_left_q == '0);
  assign block_end = line_end && (lines_left_q == '0);
  assign step      = fire && !line_end;
  assign next_line = fire && line_end && !block_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_left_q  <= '0;
      reload_q     <= '0;
      lines_left_q <= '0;
    end else if (load) begin
      xfer_left_q  <= count_m1;
      reload_q     <= count_m1;
      lines_left_q <= rect_en ? lines_m1 : '0;
    end else if (step) begin
      xfer_left_q  <= xfer_left_q - 1'b1;
    end else if (next_line) begin
      xfer_left_q  <= reload_q;
      lines_left_q <= lines_left_q - 1'b1;
    end
  end

endmodule

// File: rtl/rdag_top.sv
module rdag_top
  import rdag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned LINE_W   = 10,
  parameter int unsigned STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   cfg_src_base,
  input  logic [ADDR_W-1:0]   cfg_dst_base,
  input  logic [1:0]          cfg_size,
  input  logic [1:0]          cfg_src_inc,
  input  logic [1:0]          cfg_dst_inc,
  input  logic [CNT_W-1:0]    cfg_count_m1,
  input  logic                cfg_rect_en,
  input  logic [LINE_W-1:0]   cfg_lines_m1,
  input  logic [STRIDE_W-1:0] cfg_src_stride,
  input  logic [STRIDE_W-1:0] cfg_dst_stride,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   src_addr,
  output logic [ADDR_W-1:0]   dst_addr,
  output logic [1:0]          size_code,
  output logic                line_last,
  output logic                block_last
);

  logic valid_q;
  logic [1:0] size_q;
  logic load, fire;
  logic line_end, block_end, step, next_line;

  logic [NUM_SIDES-1:0][ADDR_W-1:0]   side_base;
  logic [NUM_SIDES-1:0][1:0]          side_inc;
  logic [NUM_SIDES-1:0][STRIDE_W-1:0] side_stride;
  logic [NUM_SIDES-1:0][ADDR_W-1:0]   side_addr;

  assign load = start && !valid_q;
  assign fire = valid_q && out_ready;

  assign side_base[SIDE_SRC]   = cfg_src_base;
  assign side_base[SIDE_DST]   = cfg_dst_base;
  assign side_inc[SIDE_SRC]    = cfg_src_inc;
  assign side_inc[SIDE_DST]    = cfg_dst_inc;
  assign side_stride[SIDE_SRC] = cfg_src_stride;
  assign side_stride[SIDE_DST] = cfg_dst_stride;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      size_q  <= 2'd0;
    end else if (load) begin
      valid_q <= 1'b1;
      size_q  <= cfg_size;
    end else if (fire && block_end) begin
      valid_q <= 1'b0;
    end
  end

  rdag_counter #(
    .CNT_W (CNT_W),
    .LINE_W(LINE_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .count_m1 (cfg_count_m1),
    .rect_en  (cfg_rect_en),
    .lines_m1 (cfg_lines_m1),
    .fire     (fire),
    .line_end (line_end),
    .block_end(block_end),
    .step     (step),
    .next_line(next_line)
  );

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    rdag_side #(
      .ADDR_W  (ADDR_W),
      .STRIDE_W(STRIDE_W)
    ) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .base     (side_base[g]),
      .inc_code (side_inc[g]),
      .stride   (side_stride[g]),
      .step     (step),
      .next_line(next_line),
      .addr     (side_addr[g])
    );
  end

  assign out_valid  = valid_q;
  assign src_addr   = side_addr[SIDE_SRC];
  assign dst_addr   = side_addr[SIDE_DST];
  assign size_code  = size_q;
  assign line_last  = valid_q && line_end;
  assign block_last = valid_q && block_end;

endmodule

// File: rtl/rdag_checker.sv
module rdag_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [1:0]        size_code,
  input logic              line_last,
  input logic              block_last
);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(src_addr) && $stable(dst_addr) &&
      $stable(size_code) && $stable(line_last) && $stable(block_last))); // R8

  AST_BLOCK_IMPLIES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    block_last |-> (line_last && out_valid)); // R7

  AST_DONE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && block_last) |=> !out_valid); // R7

  AST_IDLE_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !start) |=> !out_valid); // R1

  AST_START_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && start) |=> out_valid); // R2

  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(size_code)); // R4

endmodule

bind rdag_top rdag_checker #(.ADDR_W(ADDR_W)) u_rdag_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .src_addr  (src_addr),
  .dst_addr  (dst_addr),
  .size_code (size_code),
  .line_last (line_last),
  .block_last(block_last)
);

// File: tb/tb_rdag_top.sv
module tb_rdag_top;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned CNT_W    = 10;
  localparam int unsigned LINE_W   = 10;
  localparam int unsigned STRIDE_W = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [ADDR_W-1:0]   cfg_src_base = '0;
  logic [ADDR_W-1:0]   cfg_dst_base = '0;
  logic [1:0]          cfg_size = '0;
  logic [1:0]          cfg_src_inc = '0;
  logic [1:0]          cfg_dst_inc = '0;
  logic [CNT_W-1:0]    cfg_count_m1 = '0;
  logic                cfg_rect_en = 1'b0;
  logic [LINE_W-1:0]   cfg_lines_m1 = '0;
  logic [STRIDE_W-1:0] cfg_src_stride = '0;
  logic [STRIDE_W-1:0] cfg_dst_stride = '0;
  logic                out_valid;
  logic                out_ready = 1'b0;
  logic [ADDR_W-1:0]   src_addr;
  logic [ADDR_W-1:0]   dst_addr;
  logic [1:0]          size_code;
  logic                line_last;
  logic                block_last;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  rdag_top #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W), .STRIDE_W(STRIDE_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_size(cfg_size), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_count_m1(cfg_count_m1), .cfg_rect_en(cfg_rect_en),
    .cfg_lines_m1(cfg_lines_m1), .cfg_src_stride(cfg_src_stride),
    .cfg_dst_stride(cfg_dst_stride), .out_valid(out_valid),
    .out_ready(out_ready), .src_addr(src_addr), .dst_addr(dst_addr),
    .size_code(size_code), .line_last(line_last), .block_last(block_last)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint inc_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic run_case(input longint sb, input longint db, input int sz,
                          input int si, input int di, input int nm1,
                          input bit rect, input int lm1, input int ss,
                          input int ds, input bit stutter, input bit disturb);
    int lines = rect ? lm1 + 1 : 1;
    int total = (nm1 + 1) * lines;
    int idx = 0;
    int guard = 0;
    bit stalled = 0;
    logic [ADDR_W-1:0] hs = '0;
    logic [ADDR_W-1:0] hd = '0;
    @(negedge clk);
    cfg_src_base = sb[ADDR_W-1:0]; cfg_dst_base = db[ADDR_W-1:0];
    cfg_size = sz[1:0]; cfg_src_inc = si[1:0]; cfg_dst_inc = di[1:0];
    cfg_count_m1 = nm1[CNT_W-1:0]; cfg_rect_en = rect;
    cfg_lines_m1 = lm1[LINE_W-1:0];
    cfg_src_stride = ss[STRIDE_W-1:0]; cfg_dst_stride = ds[STRIDE_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(out_valid == 1'b1, "R2 valid after start", out_valid, 1);
    while (idx < total && guard < 5000) begin
      guard++;
      if (stalled) begin
        chk(src_addr == hs && dst_addr == hd, "R8 hold during stall", src_addr, hs);
      end
      out_ready = stutter ? ((cyc % 3) != 1) : 1'b1;
      if (disturb && idx == 1) begin
        start = 1'b1;
        cfg_src_base = 32'h7000_0000; cfg_src_inc = 2'd2;
        cfg_count_m1 = '0; cfg_rect_en = 1'b0; cfg_size = 2'd3;
      end else begin
        start = 1'b0;
      end
      stalled = out_valid && !out_ready;
      hs = src_addr; hd = dst_addr;
      if (out_valid && out_ready) begin
        int l = idx / (nm1 + 1);
        int k = idx % (nm1 + 1);
        longint es = (sb + longint'(l) * ss + longint'(k) * inc_of(si)) & 64'hFFFF_FFFF;
        longint ed = (db + longint'(l) * ds + longint'(k) * inc_of(di)) & 64'hFFFF_FFFF;
        string tg = (k == 0 && l != 0) ? "R6 line restart" : (disturb ? "R9 addr" : "R3 addr");
        chk(src_addr == es[ADDR_W-1:0], {tg, " src"}, src_addr, es);
        chk(dst_addr == ed[ADDR_W-1:0], {tg, " dst"}, dst_addr, ed);
        chk(line_last == (k == nm1), "R5 line_last", line_last, (k == nm1));
        chk(block_last == (k == nm1 && l == lines - 1), "R7 block_last",
            block_last, (k == nm1 && l == lines - 1));
        chk(size_code == sz[1:0], "R4 size_code", size_code, sz);
        idx++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R7 valid low after block", out_valid, 0);
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 stays idle", out_valid, 0);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle without start", out_valid, 0);
    for (int si = 0; si < 4; si++) begin
      for (int di = 0; di < 4; di++) begin
        for (int c = 0; c < 5; c++) begin
          int nm1, lm1;
          bit rect;
          case (c)
            0: begin nm1 = 0; rect = 0; lm1 = 0; end
            1: begin nm1 = 2; rect = 0; lm1 = 0; end
            2: begin nm1 = 1; rect = 0; lm1 = 2; end
            3: begin nm1 = 2; rect = 1; lm1 = 2; end
            default: begin nm1 = 0; rect = 1; lm1 = 3; end
          endcase
          run_case(64'h1000_0000 + 64'(si * 256), 64'h2000_0000 + 64'(di * 16),
                   (si + di + c) % 3, si, di, nm1, rect, lm1,
                   40 + c, 100 + di, run[0], (run % 3) == 2);
          run++;
        end
      end
    end
    run_case(64'hFFFF_F000, 64'h4000_0000, 2, 2, 3, 1023, 1'b0, 0, 0, 0, 1'b0, 1'b1);
    run_case(64'h0000_0100, 64'h0000_0800, 1, 1, 0, 3, 1'b1, 2, 16'hFFFF, 16'h0010, 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule